// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a small processor whose arithmetic instructions name no operands. Every value passes through an on-chip evaluation stack: a push instruction copies a data-memory word onto the stack, a pop instruction moves the top entry back out to data memory, and each arithmetic instruction consumes the two topmost entries and leaves one result in their place. Programs are fetched from a separate instruction memory, one word per instruction, until a halt instruction stops the core.

Both memories are synchronous: an address presented in one cycle returns its data in the next. The core offers sticky flags for stack overflow, stack underflow and division by zero, and a halt output that tells the surrounding logic the program has finished. An expression such as (A + B*C) / (D - E*F) is evaluated by pushing the operands so that, for subtraction and division, the left operand sits just beneath the right one.

Top module: `stk_core`

## Requirements
- R1: While reset is high and after its release, the instruction address is 0, halted is low, all three flags are low and the stack is empty (a pop straight after reset is an underflow and writes nothing).
- R2: A push reads the data word at its address field and places it on top of the stack.
- R3: A pop writes the top entry to data memory at its address field and removes it from the stack.
- R4: ADD replaces the two top entries with their sum modulo 2^16; MUL replaces them with the low 16 bits of their unsigned product.
- R5: SUB and DIV take the entry beneath the top as left operand and the top as right operand; SUB gives left minus right modulo 2^16, DIV gives the unsigned truncated quotient.
- R6: DIV with a zero right operand replaces the two entries with 0 and sets the sticky divide-by-zero flag.
- R7: The stack holds 8 entries; a push onto a full stack is discarded (no entry changes) and sets the sticky overflow flag.
- R8: A pop on an empty stack, or an arithmetic instruction with fewer than two entries, sets the sticky underflow flag, leaves the stack unchanged and writes no memory.
- R9: An instruction word carries its opcode in bits 15:13 (000 push, 001 pop, 010 ADD, 011 SUB, 100 MUL, 101 DIV, 110 no operation, 111 halt) and its address in bits 11:0; bit 12, and the address field of arithmetic and no-operation words, have no effect.
- R10: A halt instruction raises halted, which then stays high; the instruction address freezes at the halt word and no data memory access follows.
- R11: A push takes 3 cycles and every other instruction 2 cycles, both memories having one cycle of read latency; the instruction address advances by exactly one per completed non-halt instruction.
- R12: The program pushing C, B, MUL, A, ADD, D, F, E, MUL, SUB, DIV, then popping to X leaves (A + B*C) / (D - E*F) in X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction memory read address (program counter) |
| imem_rdata | input | 16 | Instruction word, valid the cycle after its address |
| dmem_addr | output | 12 | Data memory address |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 16 | Data memory write word |
| dmem_rdata | input | 16 | Data memory read word, valid the cycle after the read strobe |
| halted | output | 1 | High once a halt instruction has executed |
| ovf_flag | output | 1 | Sticky stack overflow flag |
| unf_flag | output | 1 | Sticky stack underflow flag |
| dz_flag | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions take for granted that both memories answer exactly one cycle after the address and that reset is held across at least one rising edge before a program starts; the bench models each memory as a registered array read on every edge and only changes program or data contents while reset is held. They also assume the instruction word stays stable while the core sits on one program counter value, which the registered model guarantees because the counter only moves at instruction boundaries. Test programs push operands so that the left operand of SUB and DIV lies beneath the right one, matching the stated operand order.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 3;
    localparam int ADDR_W = 12;
    localparam int INSN_W = OP_W + 1 + ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MUL  = 3'd4,
        OP_DIV  = 3'd5,
        OP_NOP  = 3'd6,
        OP_HALT = 3'd7
    } opcode_e;

    typedef struct packed {
        opcode_e             op;
        logic                rsv;
        logic [ADDR_W-1:0]   addr;
    } insn_t;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_LOAD,
        ST_HALT
    } core_state_e;

    typedef enum logic [1:0] {
        SK_HOLD,
        SK_PUSH,
        SK_POP,
        SK_FOLD
    } stack_op_e;

    function automatic logic is_arith(input opcode_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/stk_store.sv
`timescale 1ns/1ps
module stk_store import stk_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  stack_op_e                     op,
    input  logic [W-1:0]                  wr_data,
    output logic [W-1:0]                  top,
    output logic [W-1:0]                  nxt,
    output logic [$clog2(DEPTH+1)-1:0]    cnt
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     ent [DEPTH];
    logic [DEPTH-1:0] we_vec;
    logic [IDX_W-1:0] top_i;
    logic [IDX_W-1:0] nxt_i;

    // Entry i is written by a push when i entries are live, or by a fold
    // (two popped, one pushed) when i+2 entries are live.
    for (genvar i = 0; i < DEPTH; i++) begin : g_we
        assign we_vec[i] = ((op == SK_PUSH) && (cnt == CNT_W'(i))) ||
                           ((op == SK_FOLD) && (cnt == CNT_W'(i + 2)));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we_vec[i]) ent[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                SK_PUSH: cnt <= cnt + CNT_W'(1);
                SK_POP,
                SK_FOLD: cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign top_i = IDX_W'(cnt - CNT_W'(1));
    assign nxt_i = IDX_W'(cnt - CNT_W'(2));

    always_comb begin
        top = (cnt >= CNT_W'(1)) ? ent[top_i] : '0;
        nxt = (cnt >= CNT_W'(2)) ? ent[nxt_i] : '0;
    end

endmodule

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
module stk_alu import stk_pkg::*; #(
    parameter int W = 16
) (
    input  opcode_e        op,
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   res,
    output logic           div0
);
    logic [2*W-1:0] prod;

    assign prod = lhs * rhs;

    always_comb begin
        res  = '0;
        div0 = 1'b0;
        case (op)
            OP_ADD: res = lhs + rhs;
            OP_SUB: res = lhs - rhs;
            OP_MUL: res = prod[W-1:0];
            OP_DIV: begin
                if (rhs == '0) div0 = 1'b1;
                else           res  = lhs / rhs;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/stk_core.sv
`timescale 1ns/1ps
module stk_core import stk_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [PC_W-1:0]      imem_addr,
    input  logic [INSN_W-1:0]    imem_rdata,
    output logic [ADDR_W-1:0]    dmem_addr,
    output logic                 dmem_re,
    output logic                 dmem_we,
    output logic [DATA_W-1:0]    dmem_wdata,
    input  logic [DATA_W-1:0]    dmem_rdata,
    output logic                 halted,
    output logic                 ovf_flag,
    output logic                 unf_flag,
    output logic                 dz_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    insn_t             ir;
    core_state_e       state_q, state_d;
    logic [PC_W-1:0]   pc_q;
    logic              pc_inc;
    logic              set_ovf, set_unf, set_dz;
    stack_op_e         sk_op;
    logic [DATA_W-1:0] sk_wd;
    logic [DATA_W-1:0] top_w, nxt_w, alu_res;
    logic              alu_div0;
    logic [CNT_W-1:0]  depth_cnt;
    logic              rsv_unused;

    assign ir         = insn_t'(imem_rdata);
    assign rsv_unused = ir.rsv;

    stk_store #(.DEPTH(DEPTH), .W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .op      (sk_op),
        .wr_data (sk_wd),
        .top     (top_w),
        .nxt     (nxt_w),
        .cnt     (depth_cnt)
    );

    // Beneath-top is the left operand, top is the right operand.
    stk_alu #(.W(DATA_W)) u_alu (
        .op   (ir.op),
        .lhs  (nxt_w),
        .rhs  (top_w),
        .res  (alu_res),
        .div0 (alu_div0)
    );

    always_comb begin
        state_d    = state_q;
        pc_inc     = 1'b0;
        set_ovf    = 1'b0;
        set_unf    = 1'b0;
        set_dz     = 1'b0;
        sk_op      = SK_HOLD;
        sk_wd      = alu_res;
        dmem_re    = 1'b0;
        dmem_we    = 1'b0;
        dmem_addr  = ir.addr;
        dmem_wdata = top_w;
        case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC: begin
                state_d = ST_FETCH;
                pc_inc  = 1'b1;
                if (ir.op == OP_PUSH) begin
                    if (depth_cnt == CNT_W'(DEPTH)) begin
                        set_ovf = 1'b1;
                    end else begin
                        dmem_re = 1'b1;
                        pc_inc  = 1'b0;
                        state_d = ST_LOAD;
                    end
                end else if (ir.op == OP_POP) begin
                    if (depth_cnt == '0) begin
                        set_unf = 1'b1;
                    end else begin
                        dmem_we = 1'b1;
                        sk_op   = SK_POP;
                    end
                end else if (is_arith(ir.op)) begin
                    if (depth_cnt < CNT_W'(2)) begin
                        set_unf = 1'b1;
                    end else begin
                        sk_op  = SK_FOLD;
                        set_dz = alu_div0;
                    end
                end else if (ir.op == OP_HALT) begin
                    pc_inc  = 1'b0;
                    state_d = ST_HALT;
                end
            end
            ST_LOAD: begin
                sk_op   = SK_PUSH;
                sk_wd   = dmem_rdata;
                pc_inc  = 1'b1;
                state_d = ST_FETCH;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_FETCH;
            pc_q     <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
            dz_flag  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pc_inc)  pc_q     <= pc_q + PC_W'(1);
            if (set_ovf) ovf_flag <= 1'b1;
            if (set_unf) unf_flag <= 1'b1;
            if (set_dz)  dz_flag  <= 1'b1;
        end
    end

    assign imem_addr = pc_q;
    assign halted    = (state_q == ST_HALT);

endmodule

// File: rtl/stk_core_chk.sv
`timescale 1ns/1ps
module stk_core_chk #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 12
) (
    input logic                       clk,
    input logic                       rst,
    input logic [PC_W-1:0]            imem_addr,
    input logic                       dmem_re,
    input logic                       dmem_we,
    input logic                       halted,
    input logic                       ovf_flag,
    input logic                       unf_flag,
    input logic                       dz_flag,
    input logic [$clog2(DEPTH+1)-1:0] cnt
);
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!dmem_re && !dmem_we));

    p_rw_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(dmem_re && dmem_we));

    p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(imem_addr) |-> (imem_addr == $past(imem_addr) + PC_W'(1)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= ($bits(cnt))'(DEPTH));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ($past(cnt) == ($bits(cnt))'(DEPTH)) && (cnt == $past(cnt)));

    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        unf_flag |=> unf_flag);

    p_unf_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(unf_flag) |-> ($past(cnt) < ($bits(cnt))'(2)) && (cnt == $past(cnt)));

    p_dz_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        dz_flag |=> dz_flag);

endmodule

bind stk_core stk_core_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_re   (dmem_re),
    .dmem_we   (dmem_we),
    .halted    (halted),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag),
    .dz_flag   (dz_flag),
    .cnt       (depth_cnt)
);

// File: tb/stk_core_tb_top.sv
`timescale 1ns/1ps
module stk_core_tb_top;
    import stk_pkg::*;

    localparam logic [15:0] FILL = 16'hA5A5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic [11:0] imem_addr;
    logic [15:0] imem_q;
    logic [11:0] dmem_addr;
    logic        dmem_re, dmem_we;
    logic [15:0] dmem_wdata;
    logic [15:0] dmem_q;
    logic        halted, ovf_flag, unf_flag, dz_flag;

    logic [15:0] imem [64];
    logic [15:0] dmem [256];
    logic        wipe    = 1'b0;
    logic        poke_en = 1'b0;
    logic [7:0]  poke_a  = '0;
    logic [15:0] poke_d  = '0;

    int total = 0;
    int bad   = 0;
    int wp    = 0;

    stk_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_q),
        .dmem_addr  (dmem_addr),
        .dmem_re    (dmem_re),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_q),
        .halted     (halted),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag),
        .dz_flag    (dz_flag)
    );

    // Registered memories: one cycle of read latency.
    always @(posedge clk) begin
        imem_q <= imem[imem_addr[5:0]];
        dmem_q <= dmem[dmem_addr[7:0]];
        if (wipe) begin
            for (int i = 0; i < 256; i++) dmem[i] <= FILL;
        end else if (poke_en) begin
            dmem[poke_a] <= poke_d;
        end else if (dmem_we) begin
            dmem[dmem_addr[7:0]] <= dmem_wdata;
        end
    end

    // {op, left, right, expected, divide-by-zero}
    localparam logic [51:0] VECS [9] = '{
        {3'd2, 16'h0003, 16'h0004, 16'h0007, 1'b0},
        {3'd2, 16'hFFFF, 16'h0002, 16'h0001, 1'b0},
        {3'd3, 16'h000A, 16'h0003, 16'h0007, 1'b0},
        {3'd3, 16'h0003, 16'h000A, 16'hFFF9, 1'b0},
        {3'd4, 16'h012C, 16'h012C, 16'h5F90, 1'b0},
        {3'd4, 16'h0007, 16'h0006, 16'h002A, 1'b0},
        {3'd5, 16'h0064, 16'h0007, 16'h000E, 1'b0},
        {3'd5, 16'h0007, 16'h0064, 16'h0000, 1'b0},
        {3'd5, 16'h0005, 16'h0000, 16'h0000, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [2:0] op, input logic [11:0] a,
                                        input logic b12);
        return {op, b12, a};
    endfunction

    task automatic emit(input logic [2:0] op, input logic [11:0] a);
        imem[wp] = ins(op, a, 1'b0);
        wp++;
    endtask

    // Hold reset, fill data memory, clear program.
    task automatic setup();
        rst = 1'b1;
        @(negedge clk);
        wipe = 1'b1;
        @(negedge clk);
        wipe = 1'b0;
        for (int i = 0; i < 64; i++) imem[i] = ins(3'd7, 12'd0, 1'b0);
        wp = 0;
    endtask

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        poke_a  = a;
        poke_d  = d;
        poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) chk("R10", "program reached halt", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog: got no finish expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        int strobes;

        // R1: state while reset is held
        setup();
        chk("R1", "imem_addr in reset", 32'(imem_addr), 32'd0);
        chk("R1", "halted in reset", 32'(halted), 32'd0);
        chk("R1", "flags in reset", {29'd0, ovf_flag, unf_flag, dz_flag}, 32'd0);

        // R4 R5 R6: arithmetic vectors, left operand pushed first
        for (int k = 0; k < 9; k++) begin
            logic [51:0] v;
            string tag;
            v = VECS[k];
            tag = (v[0]) ? "R6" : ((v[51:49] == 3'd3 || v[51:49] == 3'd5) ? "R5" : "R4");
            setup();
            poke(8'd0, v[48:33]);
            poke(8'd1, v[32:17]);
            emit(3'd0, 12'd0);
            emit(3'd0, 12'd1);
            emit(v[51:49], 12'd0);
            emit(3'd1, 12'd2);
            run(cyc);
            chk(tag, $sformatf("vector %0d result", k), 32'(dmem[2]), 32'(v[16:1]));
            chk(tag, $sformatf("vector %0d dz flag", k), 32'(dz_flag), 32'(v[0]));
        end

        // R2 R3 R10 R11: timing of push, pop, halt
        setup();
        poke(8'd3, 16'h1234);
        emit(3'd0, 12'd3);
        emit(3'd1, 12'd4);
        run(cyc);
        chk("R11", "cycles from reset release to halt", 32'(cyc), 32'd7);
        chk("R2", "pushed word reaches stack", 32'(dmem[4]), 32'h1234);
        chk("R3", "popped word written", 32'(dmem[4]), 32'h1234);
        chk("R10", "imem_addr frozen at halt word", 32'(imem_addr), 32'd2);
        strobes = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (dmem_re || dmem_we) strobes++;
        end
        chk("R10", "memory strobes after halt", 32'(strobes), 32'd0);
        chk("R10", "halted stays high", 32'(halted), 32'd1);
        chk("R10", "imem_addr still frozen", 32'(imem_addr), 32'd2);

        // R7: nine pushes onto an eight-entry stack
        setup();
        for (int i = 0; i < 9; i++) poke(8'(i), 16'h0100 + 16'(i));
        for (int i = 0; i < 9; i++) emit(3'd0, 12'(i));
        for (int i = 0; i < 8; i++) emit(3'd1, 12'(16 + i));
        run(cyc);
        chk("R7", "overflow flag", 32'(ovf_flag), 32'd1);
        chk("R7", "top after discarded push", 32'(dmem[16]), 32'h0107);
        chk("R7", "bottom entry", 32'(dmem[23]), 32'h0100);
        chk("R7", "no underflow during drain", 32'(unf_flag), 32'd0);

        // R1: flags clear after reset, stack empty after reset
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "flags cleared by reset", {29'd0, ovf_flag, unf_flag, dz_flag}, 32'd0);
        chk("R1", "imem_addr after reset", 32'(imem_addr), 32'd0);
        setup();
        emit(3'd1, 12'd30);
        run(cyc);
        chk("R1", "pop after reset is underflow", 32'(unf_flag), 32'd1);
        chk("R1", "pop after reset writes nothing", 32'(dmem[30]), 32'(FILL));

        // R8: arithmetic with one entry, pop on empty
        setup();
        poke(8'd0, 16'h0005);
        emit(3'd0, 12'd0);
        emit(3'd2, 12'd0);
        emit(3'd1, 12'd1);
        emit(3'd1, 12'd2);
        run(cyc);
        chk("R8", "underflow flag", 32'(unf_flag), 32'd1);
        chk("R8", "entry kept after failed ADD", 32'(dmem[1]), 32'h0005);
        chk("R8", "empty pop writes nothing", 32'(dmem[2]), 32'(FILL));
        chk("R8", "no overflow", 32'(ovf_flag), 32'd0);

        // R9: spare bit, arithmetic address field and no-operation
        setup();
        poke(8'd0, 16'h0020);
        poke(8'd1, 16'h0022);
        emit(3'd0, 12'd0);
        emit(3'd0, 12'd1);
        imem[wp] = ins(3'd6, 12'h0FF, 1'b1); wp++;
        imem[wp] = ins(3'd2, 12'h0FF, 1'b1); wp++;
        emit(3'd1, 12'd2);
        run(cyc);
        chk("R9", "ADD with address field and bit 12", 32'(dmem[2]), 32'h0042);
        chk("R9", "address field causes no write", 32'(dmem[8'hFF]), 32'(FILL));
        chk("R9", "no flags raised", {29'd0, ovf_flag, unf_flag, dz_flag}, 32'd0);
        chk("R11", "pc after five instructions", 32'(imem_addr), 32'd5);

        // R12: (A + B*C) / (D - E*F)
        setup();
        poke(8'd10, 16'd100);
        poke(8'd11, 16'd5);
        poke(8'd12, 16'd4);
        poke(8'd13, 16'd20);
        poke(8'd14, 16'd2);
        poke(8'd15, 16'd3);
        emit(3'd0, 12'd12);
        emit(3'd0, 12'd11);
        emit(3'd4, 12'd0);
        emit(3'd0, 12'd10);
        emit(3'd2, 12'd0);
        emit(3'd0, 12'd13);
        emit(3'd0, 12'd15);
        emit(3'd0, 12'd14);
        emit(3'd4, 12'd0);
        emit(3'd3, 12'd0);
        emit(3'd5, 12'd0);
        emit(3'd1, 12'd20);
        run(cyc);
        chk("R12", "expression result in X", 32'(dmem[20]), 32'd8);
        chk("R12", "no flags raised", {29'd0, ovf_flag, unf_flag, dz_flag}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule